// File: doc/BRIEF.md
# Load Way-Select Alignment Multiplexer

This block sits on the load return path of a first-level data cache. Each load presents four way words, one per way, two store-forward bypass words, and a way-hit vector, all at once. The block picks one source word. It turns the addressed bytes down to the bottom of the word and reorders them when the load is big-endian. It then widens the field to 64 bits by sign or zero extension. All of this is one merged selection network, so every result bit chooses among 48 candidates: six source words times eight byte rotations.

The network has four stages: source choice, byte rotation, endian reorder and extension. A single register stage follows it, so a request presented in one cycle gives its result after the next rising edge. A load whose field would run past the end of the 8-byte word is not served. The block instead raises a misalignment flag for that response.

Top module: `loadAlignMux`

## Requirements
- R1: The response is registered. A request with `reqValid` high in one cycle gives `rspValid` high after the next rising edge. A cycle with `reqValid` low gives `rspValid`, `rspMisalign` and `rspData` all zero after that edge.
- R2: Source priority is strict. `bypassSel[0]` selects bypass word 0 and wins over `bypassSel[1]`, which selects bypass word 1. Either bypass wins over any way hit.
- R3: With no bypass asserted, the single set bit `wayHit[w]` selects way word `w`. With no bypass and no hit, the source word is all zeros. The way-hit vector is at most one-hot.
- R4: For a little-endian load, result byte `j` (j below the access size) equals source byte `byteOffset + j`. Byte 0 is bits 7:0.
- R5: When `bigEndian` is 1, result byte `j` (j below the access size) equals source byte `byteOffset + size - 1 - j`.
- R6: `accSize` is the base-2 logarithm of the access size in bytes: 0 means 1 byte, 1 means 2, 2 means 4 and 3 means 8. Result bytes at or above the size are filled by extension.
- R7: When `signedLoad` is 0, all result bits above the field are zero.
- R8: When `signedLoad` is 1, all result bits above the field copy bit 7 of the most significant result byte of the field (byte size-1, after endian reordering).
- R9: When `byteOffset + size` exceeds 8, `rspMisalign` is 1 and `rspData` is zero. Otherwise `rspMisalign` is 0.
- R10: While `rstN` is low, `rspValid`, `rspMisalign` and `rspData` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | A load request is presented this cycle |
| wayData | input | 4x64 | Data word read from each way |
| bypassData | input | 2x64 | Store-forward bypass words |
| wayHit | input | 4 | One-hot (or zero) way hit vector |
| bypassSel | input | 2 | Bypass request per bypass word |
| byteOffset | input | 3 | Byte address within the 8-byte word |
| accSize | input | 2 | Access size code (log2 of bytes) |
| signedLoad | input | 1 | 1 sign-extends, 0 zero-extends |
| bigEndian | input | 1 | 1 reverses the bytes of the field |
| rspValid | output | 1 | Result valid |
| rspData | output | 64 | Aligned, extended load result |
| rspMisalign | output | 1 | Field crossed the 8-byte boundary |

## Verification
The bench sweeps every source choice, including the case with no source, across every byte offset, size, endian mode and extension mode. It uses two data patterns in which the top bit of each byte takes both values, so every field position is tested with a sign bit set and with it clear. A rotation computed the wrong way would put the neighbouring bytes at the bottom of the result. Reordering the whole word instead of only the field would pull in bytes from outside the access. Taking the sign from the wrong byte under big-endian order would flip the fill for half the pattern. It also drives both bypass requests together with a way hit, where a wrong priority returns the wrong word. It drives fields that end exactly at byte 8 and fields one byte past it, where an off-by-one boundary test either rejects legal loads or returns data for illegal ones.

// File: rtl/loadAlignPkg.sv
package loadAlignPkg;
  parameter int LAM_WAYS   = 4;
  parameter int LAM_BYPASS = 2;
  parameter int LAM_BYTES  = 8;
  localparam int LAM_SRCS   = LAM_WAYS + LAM_BYPASS;
  localparam int LAM_WORD_W = LAM_BYTES * 8;
  localparam int OFF_W      = $clog2(LAM_BYTES);
  localparam int SIZE_W     = $clog2(OFF_W + 1);

  typedef struct packed {
    logic                load;
    logic [LAM_SRCS-1:0] srcSel;
    logic [OFF_W-1:0]    rotAmt;
    logic [OFF_W-1:0]    lastByte;
    logic                bigEndian;
    logic                signExt;
    logic                misalign;
  } lamStrobes_t;
endpackage

// File: rtl/lamCtrl.sv
module lamCtrl
  import loadAlignPkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  reqValid,
  input  logic [LAM_WAYS-1:0]   wayHit,
  input  logic [LAM_BYPASS-1:0] bypassSel,
  input  logic [OFF_W-1:0]      byteOffset,
  input  logic [SIZE_W-1:0]     accSize,
  input  logic                  signedLoad,
  input  logic                  bigEndian,
  output lamStrobes_t           strobe
);
  logic [OFF_W:0]        nBytes;
  logic [OFF_W:0]        endPos;
  logic [LAM_SRCS-1:0]   srcPick;
  logic                  bypassAny;

  // priority: lowest-numbered bypass first, then the way hit vector
  always_comb begin
    srcPick   = '0;
    bypassAny = 1'b0;
    for (int b = 0; b < LAM_BYPASS; b++) begin
      if (bypassSel[b] && !bypassAny) begin
        srcPick[LAM_WAYS + b] = 1'b1;
        bypassAny             = 1'b1;
      end
    end
    if (!bypassAny) srcPick[LAM_WAYS-1:0] = wayHit;
  end

  assign nBytes = (OFF_W+1)'(1) << accSize;
  assign endPos = {1'b0, byteOffset} + nBytes;

  always_comb begin
    strobe.load      = reqValid;
    strobe.srcSel    = srcPick;
    strobe.rotAmt    = byteOffset;
    strobe.lastByte  = OFF_W'(nBytes - (OFF_W+1)'(1));
    strobe.bigEndian = bigEndian;
    strobe.signExt   = signedLoad;
    strobe.misalign  = endPos > (OFF_W+1)'(LAM_BYTES);
  end

  AST_BYPASS0_WINS: assert property (@(posedge clk) disable iff (!rstN)
    bypassSel[0] |-> strobe.srcSel == (LAM_SRCS'(1) << LAM_WAYS)); // R2
  AST_SRC_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(wayHit) |-> $onehot0(strobe.srcSel)); // R3
  AST_FULL_WORD_OFFSET: assert property (@(posedge clk) disable iff (!rstN)
    (accSize == SIZE_W'(OFF_W) && byteOffset != '0) |-> strobe.misalign); // R9
endmodule

// File: rtl/lamData.sv
module lamData
  import loadAlignPkg::*;
(
  input  logic                                  clk,
  input  logic                                  rstN,
  input  lamStrobes_t                           strobe,
  input  logic [LAM_WAYS-1:0][LAM_WORD_W-1:0]   wayData,
  input  logic [LAM_BYPASS-1:0][LAM_WORD_W-1:0] bypassData,
  output logic                                  rspValid,
  output logic [LAM_WORD_W-1:0]                 rspData,
  output logic                                  rspMisalign
);
  logic [LAM_SRCS-1:0][LAM_WORD_W-1:0] srcWord;
  logic [LAM_WORD_W-1:0]               selWord;
  logic [LAM_BYTES-1:0][7:0]           selBytes;
  logic [LAM_BYTES-1:0][7:0]           rotBytes;
  logic [LAM_BYTES-1:0][7:0]           ordBytes;
  logic [LAM_BYTES-1:0][7:0]           extBytes;
  logic                                signBit;

  genvar g;
  generate
    for (g = 0; g < LAM_WAYS; g++) begin : gWaySrc
      assign srcWord[g] = wayData[g];
    end
    for (g = 0; g < LAM_BYPASS; g++) begin : gBypSrc
      assign srcWord[LAM_WAYS + g] = bypassData[g];
    end
  endgenerate

  // stage 1: AND-OR source choice
  always_comb begin
    selWord = '0;
    for (int s = 0; s < LAM_SRCS; s++)
      selWord |= srcWord[s] & {LAM_WORD_W{strobe.srcSel[s]}};
  end
  assign selBytes = selWord;

  // stage 4 sign source
  assign signBit = strobe.signExt & ordBytes[strobe.lastByte][7];

  generate
    for (g = 0; g < LAM_BYTES; g++) begin : gByte
      localparam logic [OFF_W-1:0] POS = OFF_W'(g);
      logic inField;
      assign inField     = POS <= strobe.lastByte;
      // stage 2: rotate the addressed byte down
      assign rotBytes[g] = selBytes[POS + strobe.rotAmt];
      // stage 3: reverse only within the field
      assign ordBytes[g] = (strobe.bigEndian && inField)
                           ? rotBytes[strobe.lastByte - POS] : rotBytes[g];
      // stage 4: extension fill
      assign extBytes[g] = inField ? ordBytes[g] : {8{signBit}};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid    <= 1'b0;
      rspMisalign <= 1'b0;
      rspData     <= '0;
    end else begin
      rspValid    <= strobe.load;
      rspMisalign <= strobe.load & strobe.misalign;
      rspData     <= (strobe.load && !strobe.misalign) ? extBytes : '0;
    end
  end

  AST_RESP_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> rspValid); // R1
  AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.load |=> (!rspValid && !rspMisalign && rspData == '0)); // R1
  AST_MISALIGN_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && strobe.misalign) |=> (rspMisalign && rspData == '0)); // R9
  AST_UNSIGNED_BYTE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && !strobe.misalign && !strobe.signExt && strobe.lastByte == '0)
      |=> rspData[LAM_WORD_W-1:8] == '0); // R7
endmodule

// File: rtl/loadAlignMux.sv
module loadAlignMux
  import loadAlignPkg::*;
(
  input  logic                                  clk,
  input  logic                                  rstN,
  input  logic                                  reqValid,
  input  logic [LAM_WAYS-1:0][LAM_WORD_W-1:0]   wayData,
  input  logic [LAM_BYPASS-1:0][LAM_WORD_W-1:0] bypassData,
  input  logic [LAM_WAYS-1:0]                   wayHit,
  input  logic [LAM_BYPASS-1:0]                 bypassSel,
  input  logic [OFF_W-1:0]                      byteOffset,
  input  logic [SIZE_W-1:0]                     accSize,
  input  logic                                  signedLoad,
  input  logic                                  bigEndian,
  output logic                                  rspValid,
  output logic [LAM_WORD_W-1:0]                 rspData,
  output logic                                  rspMisalign
);
  lamStrobes_t strobe;

  lamCtrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .wayHit     (wayHit),
    .bypassSel  (bypassSel),
    .byteOffset (byteOffset),
    .accSize    (accSize),
    .signedLoad (signedLoad),
    .bigEndian  (bigEndian),
    .strobe     (strobe)
  );

  lamData uData (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .wayData     (wayData),
    .bypassData  (bypassData),
    .rspValid    (rspValid),
    .rspData     (rspData),
    .rspMisalign (rspMisalign)
  );

  AST_MISALIGN_NO_DATA: assert property (@(posedge clk) disable iff (!rstN)
    rspMisalign |-> rspData == '0); // R9
endmodule

// File: tb/sim_loadAlignMux.sv
module sim_loadAlignMux;
  import loadAlignPkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int SRC_NONE   = LAM_SRCS;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [LAM_WAYS-1:0][LAM_WORD_W-1:0]   wayData = '0;
  logic [LAM_BYPASS-1:0][LAM_WORD_W-1:0] bypassData = '0;
  logic [LAM_WAYS-1:0]   wayHit = '0;
  logic [LAM_BYPASS-1:0] bypassSel = '0;
  logic [OFF_W-1:0]      byteOffset = '0;
  logic [SIZE_W-1:0]     accSize = '0;
  logic signedLoad = 1'b0;
  logic bigEndian = 1'b0;
  logic rspValid;
  logic [LAM_WORD_W-1:0] rspData;
  logic rspMisalign;

  int testCount = 0;
  int failCount = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  loadAlignMux u0 (.*);

  function automatic logic [7:0] patByte(int s, int b, bit pat);
    logic [7:0] v = 8'((s << 4) | b);
    if (((b & 1) != 0) ^ pat) v = v ^ 8'h80;
    return v;
  endfunction

  function automatic logic [LAM_WORD_W-1:0] patWord(int s, bit pat);
    logic [LAM_WORD_W-1:0] w = '0;
    if (s < LAM_SRCS)
      for (int b = 0; b < LAM_BYTES; b++) w[b*8 +: 8] = patByte(s, b, pat);
    return w;
  endfunction

  function automatic logic [LAM_WORD_W-1:0] model(logic [LAM_WORD_W-1:0] w,
      int off, int sz, bit be, bit sg);
    logic [LAM_WORD_W-1:0] r = '0;
    int nb = 1 << sz;
    logic sb;
    if (off + nb > LAM_BYTES) return '0;
    for (int j = 0; j < nb; j++) begin
      int k = be ? (off + nb - 1 - j) : (off + j);
      r[j*8 +: 8] = w[k*8 +: 8];
    end
    sb = sg & r[nb*8 - 1];
    for (int j = nb; j < LAM_BYTES; j++) r[j*8 +: 8] = {8{sb}};
    return r;
  endfunction

  task automatic check(string req, logic [LAM_WORD_W-1:0] act, logic [LAM_WORD_W-1:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic fillWords(bit pat);
    for (int s = 0; s < LAM_WAYS; s++) wayData[s] = patWord(s, pat);
    for (int s = 0; s < LAM_BYPASS; s++) bypassData[s] = patWord(LAM_WAYS + s, pat);
  endtask

  // called at a falling edge; result checked at the following falling edge
  task automatic runCase(int s, int off, int sz, bit be, bit sg, bit pat);
    logic [LAM_WORD_W-1:0] exp;
    bit mis;
    string tag;
    fillWords(pat);
    reqValid   = 1'b1;
    wayHit     = (s < LAM_WAYS) ? LAM_WAYS'(1) << s : '0;
    bypassSel  = (s >= LAM_WAYS && s < LAM_SRCS) ? LAM_BYPASS'(1) << (s - LAM_WAYS) : '0;
    byteOffset = OFF_W'(off);
    accSize    = SIZE_W'(sz);
    bigEndian  = be;
    signedLoad = sg;
    exp = model(patWord(s, pat), off, sz, be, sg);
    mis = (off + (1 << sz)) > LAM_BYTES;
    @(negedge clk);
    if (mis)                 tag = "R9";
    else if (s == SRC_NONE)  tag = "R3";
    else if (be)             tag = "R5";
    else if (sg)             tag = "R8";
    else if (s >= LAM_WAYS)  tag = "R2";
    else                     tag = "R4";
    check(tag, rspData, exp);
    check("R9 flag", 64'(rspMisalign), 64'(mis));
    check("R1 valid", 64'(rspValid), 64'd1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      failCount++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

  initial begin
    reqValid = 1'b1;
    fillWords(1'b0);
    wayHit = 4'b0001;
    repeat (3) @(negedge clk);
    check("R10 data", rspData, '0);
    check("R10 valid", 64'(rspValid), 64'd0);
    check("R10 misalign", 64'(rspMisalign), 64'd0);
    rstN = 1'b1;
    reqValid = 1'b0;
    @(negedge clk);

    for (int pat = 0; pat < 2; pat++)
      for (int s = 0; s <= SRC_NONE; s++)
        for (int off = 0; off < LAM_BYTES; off++)
          for (int sz = 0; sz <= OFF_W; sz++)
            for (int be = 0; be < 2; be++)
              for (int sg = 0; sg < 2; sg++)
                runCase(s, off, sz, be[0], sg[0], pat[0]);

    // R2: both bypasses plus a hit -> bypass 0; bypass 1 beats a hit
    fillWords(1'b0);
    wayHit = 4'b0100; bypassSel = 2'b11;
    byteOffset = '0; accSize = 2'd3; bigEndian = 0; signedLoad = 0; reqValid = 1;
    @(negedge clk);
    check("R2 both bypass", rspData, patWord(LAM_WAYS, 1'b0));
    bypassSel = 2'b10;
    @(negedge clk);
    check("R2 bypass1 over hit", rspData, patWord(LAM_WAYS + 1, 1'b0));

    // R6/R7: 2-byte unsigned at offset 6, a field ending exactly at byte 8
    bypassSel = 2'b00; wayHit = 4'b0010; byteOffset = 3'd6; accSize = 2'd1;
    @(negedge clk);
    check("R6 size2 end", rspData, {48'd0, patByte(1, 7, 0), patByte(1, 6, 0)});
    check("R7 upper zero", 64'(rspData[63:16]), 64'd0);
    check("R9 exact end", 64'(rspMisalign), 64'd0);

    // R1: idle cycle clears outputs
    reqValid = 1'b0;
    @(negedge clk);
    check("R1 idle data", rspData, '0);
    check("R1 idle valid", 64'(rspValid), 64'd0);
    check("R1 idle misalign", 64'(rspMisalign), 64'd0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end
endmodule